// File: doc/BRIEF.md
# External Interrupt Edge Request Unit

This block conditions a small set of external interrupt pins (two by default) for a small microcontroller core. Each pin passes through a synchronizer and an edge detector. The detector is steered by a per-pin 4-bit control register, which selects the active polarity, one-sided or both-edge detection, and whether the pin level gates an associated timer. A detected event sets a per-pin request flag. A separate enable register decides how each flag is consumed. When the enable bit is set, a pending flag raises the interrupt line for one cycle and is handed over to the core. When the enable bit is clear, software polls the flag with a skip-and-clear strobe and gets the old flag value back as a one-cycle skip pulse.

Each request flag is a two-state machine with the states FLG_IDLE and FLG_PEND. It has four named transitions. SET goes from FLG_IDLE to FLG_PEND, or holds FLG_PEND, on a pin event or a polarity-write event. TAKE goes from FLG_PEND to FLG_IDLE when the enable bit is 1. POLL_CLR goes from FLG_PEND to FLG_IDLE on a poll while the enable bit is 0. HOLD leaves the state unchanged otherwise. SET has priority over TAKE and POLL_CLR. Channel 0 drives the gate of the first timer and channel 1 drives the gate of the third timer.

A second, retaining reset models the low-power back-up wake-up. It clears the enable register and keeps the control registers, the flags and the synchronizer state.

Top module: `extint_unit`

## Requirements
- R1: After `rst_n` is asserted, every control register and the enable register read 0, and `irq`, `skip` and `tmr_gate` are all 0.
- R2: Register select values 0 and 1 address the control registers of channel 0 and channel 1, and all four bits read back as written, including bit 3, which has no function. Select 2 addresses the enable register: written bits [1:0] are stored, and bits [3:2] read 0. Select 3 reads 0 and ignores writes.
- R3: Single-edge mode is control bit 1 = 0. In this mode only a pin transition to the level given by bit 2 (1 = rising/high, 0 = falling/low) sets the flag. The flag is set on the third rising clock edge after the pin changes (two synchronizer flops, then the flag register).
- R4: Both-edge mode is control bit 1 = 1. In this mode either pin transition sets the flag, regardless of bit 2.
- R5: A write that changes bit 2 sets the flag if both of these hold: the written value selects single-edge mode, and the synchronized pin level already equals the new active level.
- R6: With the enable bit at 0, a poll strobe sampled on a clock edge produces `skip` for exactly the following cycle, carrying the flag value before the edge, and clears the flag.
- R7: With the enable bit at 1, a poll strobe has no effect (`skip` stays 0). While the flag is pending, `irq` is 1, and the flag is consumed on the next edge, so `irq` lasts one cycle per event.
- R8: If a flag-setting event and a poll clear fall on the same clock edge, the flag stays set.
- R9: `tmr_gate` equals control bit 0 ANDed with the synchronized pin level, and follows the pin two clock edges late.
- R10: A `keep_rst` pulse clears the enable register only. The control registers and the flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset |
| keep_rst | input | 1 | Synchronous retaining reset (back-up wake-up), clears the enable register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 4 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 4 | Read data (combinational) |
| pin_in | input | 2 | Asynchronous external interrupt pins |
| poll | input | 2 | Per-channel skip-and-clear poll strobes |
| skip | output | 2 | One-cycle poll result per channel |
| irq | output | 2 | Interrupt request per channel |
| tmr_gate | output | 2 | Timer count/gate control per channel |

## Verification
Several rules are checked on every cycle by properties:
- a skip pulse only follows a poll and lasts a single cycle;
- a poll made while the interrupt is enabled never yields a skip;
- the timer gate only rises when control bit 0 is set, and it tracks the pin two edges late;
- `irq` is quiet right after a retaining reset.

Other behaviours need the bench's directed scenarios, checked against a reference model on each clock: single-edge versus both-edge detection, the spurious set from a polarity write, an edge landing on the same edge as a poll clear, and register retention across `keep_rst`.

// File: rtl/extint_pkg.sv
package extint_pkg;
    localparam int CTRL_W   = 4;
    localparam int POL_BIT  = 2;
    localparam int BOTH_BIT = 1;
    localparam int TMR_BIT  = 0;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic level,
    output logic prev
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], d};
    end

    assign level = sh[STAGES-1];
    assign prev  = sh[STAGES];
endmodule

// File: rtl/extint_chan.sv
module extint_chan
    import extint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wd,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              int_en,
    input  logic              poll,
    output logic              irq,
    output logic              skip,
    output logic              tmr_gate
);
    logic level, prev;
    logic pin_ev, pol_ev, set_req, poll_ok;
    flag_state_e state, state_nxt;

    extint_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin), .level(level), .prev(prev)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_wd;
    end

    always_comb begin
        pin_ev  = (level != prev) && (ctrl_q[BOTH_BIT] || (level == ctrl_q[POL_BIT]));
        pol_ev  = ctrl_we && (ctrl_wd[POL_BIT] != ctrl_q[POL_BIT])
                  && !ctrl_wd[BOTH_BIT] && (level == ctrl_wd[POL_BIT]);
        set_req = pin_ev || pol_ev;
        poll_ok = poll && !int_en;
    end

    // transitions: SET, TAKE, POLL_CLR, HOLD
    always_comb begin
        state_nxt = state;
        unique case (state)
            FLG_IDLE: if (set_req) state_nxt = FLG_PEND;
            FLG_PEND: begin
                if (set_req)      state_nxt = FLG_PEND;
                else if (int_en)  state_nxt = FLG_IDLE;
                else if (poll_ok) state_nxt = FLG_IDLE;
            end
            default: state_nxt = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLG_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) skip <= 1'b0;
        else        skip <= poll_ok && (state == FLG_PEND);
    end

    always_comb begin
        irq      = (state == FLG_PEND) && int_en;
        tmr_gate = ctrl_q[TMR_BIT] && level;
    end
endmodule

// File: rtl/extint_unit.sv
module extint_unit
    import extint_pkg::*;
#(
    parameter  int NCH         = 2,
    parameter  int SYNC_STAGES = 2,
    localparam int SEL_W       = $clog2(NCH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep_rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CTRL_W-1:0] rd_data,
    input  logic [NCH-1:0]    pin_in,
    input  logic [NCH-1:0]    poll,
    output logic [NCH-1:0]    skip,
    output logic [NCH-1:0]    irq,
    output logic [NCH-1:0]    tmr_gate
);
    localparam logic [SEL_W-1:0] EN_SEL = SEL_W'(NCH);

    logic [NCH-1:0][CTRL_W-1:0] ctrl_w;
    logic [NCH-1:0]             en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         en_q <= '0;
        else if (keep_rst)                  en_q <= '0;
        else if (wr_en && wr_sel == EN_SEL) en_q <= wr_data[NCH-1:0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        extint_chan #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk(clk), .rst_n(rst_n), .pin(pin_in[i]),
            .ctrl_we(wr_en && (wr_sel == SEL_W'(i))), .ctrl_wd(wr_data),
            .ctrl_q(ctrl_w[i]), .int_en(en_q[i]), .poll(poll[i]),
            .irq(irq[i]), .skip(skip[i]), .tmr_gate(tmr_gate[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++)
            if (rd_sel == SEL_W'(i)) rd_data = ctrl_w[i];
        if (rd_sel == EN_SEL) rd_data[NCH-1:0] = en_q;
    end
endmodule

// File: rtl/extint_unit_chk.sv
module extint_unit_chk #(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 keep_rst,
    input logic [NCH-1:0]       pin_in,
    input logic [NCH-1:0]       poll,
    input logic [NCH-1:0]       skip,
    input logic [NCH-1:0]       irq,
    input logic [NCH-1:0]       tmr_gate,
    input logic [NCH-1:0]       en_q,
    input logic [NCH-1:0][3:0]  ctrl_w
);
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_skip_after_poll_r6: assert property (@(posedge clk) disable iff (!rst_n)
            skip[g] |-> $past(poll[g]));
        p_skip_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (skip[g] && !poll[g]) |=> !skip[g]);
        p_poll_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (poll[g] && en_q[g]) |=> !skip[g]);
        p_gate_needs_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_gate[g] |-> ctrl_w[g][0]);
        p_gate_tracks_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_gate[g] |-> $past(pin_in[g], SYNC_STAGES));
        p_keep_quiets_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
            $past(keep_rst) |-> !irq[g]);
    end
endmodule

bind extint_unit extint_unit_chk #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .keep_rst(keep_rst), .pin_in(pin_in), .poll(poll),
    .skip(skip), .irq(irq), .tmr_gate(tmr_gate), .en_q(en_q), .ctrl_w(ctrl_w)
);

// File: tb/sim_extint_unit.sv
`timescale 1ns/1ps
module sim_extint_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       keep_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [3:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [3:0] rd_data;
    logic [1:0] pin_in = '0;
    logic [1:0] poll = '0;
    logic [1:0] skip, irq, tmr_gate;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    extint_unit u0 (
        .clk(clk), .rst_n(rst_n), .keep_rst(keep_rst), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .pin_in(pin_in), .poll(poll), .skip(skip), .irq(irq), .tmr_gate(tmr_gate)
    );

    // behavioural reference model
    int   m_s1[2], m_s2[2], m_s3[2];
    bit   m_flag[2], m_skip[2];
    bit [3:0] m_ctrl[2];
    bit [1:0] m_en;

    always @(posedge clk) begin
        bit ev, pw, take, pv, nf;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_s1[c] = 0; m_s2[c] = 0; m_s3[c] = 0;
                m_flag[c] = 0; m_skip[c] = 0; m_ctrl[c] = 0;
            end
            m_en = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                ev = (m_s2[c] != m_s3[c]) && (m_ctrl[c][1] || (m_s2[c] == int'(m_ctrl[c][2])));
                pw = wr_en && (wr_sel == c) && (wr_data[2] != m_ctrl[c][2])
                     && !wr_data[1] && (m_s2[c] == int'(wr_data[2]));
                take = m_flag[c] && m_en[c];
                pv   = poll[c] && !m_en[c];
                m_skip[c] = pv && m_flag[c];
                nf = m_flag[c];
                if (ev || pw) nf = 1;
                else if (take || pv) nf = 0;
                m_flag[c] = nf;
                if (wr_en && wr_sel == c) m_ctrl[c] = wr_data;
                m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = int'(pin_in[c]);
            end
            if (keep_rst) m_en = 0;
            else if (wr_en && wr_sel == 2) m_en = wr_data[1:0];
        end
    end

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        logic [3:0] er;
        cyc++;
        if (rst_n) begin
            for (int c = 0; c < 2; c++) begin
                check("R7 irq model", {3'b0, irq[c]}, {3'b0, m_flag[c] & m_en[c]});
                check("R6 skip model", {3'b0, skip[c]}, {3'b0, m_skip[c]});
                check("R9 gate model", {3'b0, tmr_gate[c]},
                      {3'b0, m_ctrl[c][0] & (m_s2[c] != 0)});
            end
            er = 4'h0;
            if (rd_sel < 2) er = m_ctrl[rd_sel[0]];
            else if (rd_sel == 2) er = {2'b00, m_en};
            check("R2 read model", rd_data, er);
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] s, input logic [3:0] d);
        @(posedge clk); #1; wr_en = 1; wr_sel = s; wr_data = d;
        @(posedge clk); #1; wr_en = 0;
    endtask

    task automatic rd(input logic [1:0] s, input logic [3:0] exp, input string tag);
        @(posedge clk); #1; rd_sel = s; #1;
        check(tag, rd_data, exp);
    endtask

    task automatic do_poll(input int c, input bit exp, input string tag);
        @(posedge clk); #1; poll[c] = 1;
        @(posedge clk); #1; poll[c] = 0;
        check(tag, {3'b0, skip[c]}, {3'b0, exp});
    endtask

    initial begin
        int seen;
        step(4);
        rst_n = 1;
        step(1);
        // R1 reset state
        check("R1 outputs", {irq, skip}, 4'h0);
        check("R1 gate", {2'b0, tmr_gate}, 4'h0);
        rd(0, 4'h0, "R1 ctrl0");
        rd(1, 4'h0, "R1 ctrl1");
        rd(2, 4'h0, "R1 enable");
        // R2 register access
        wr(0, 4'b1000); rd(0, 4'b1000, "R2 bit3 readback");
        wr(3, 4'hF);    rd(3, 4'h0, "R2 select 3 ignored");
        wr(2, 4'b1100); rd(2, 4'h0, "R2 enable upper bits");
        // R3 single rising edge
        wr(0, 4'b0100);
        do_poll(0, 0, "R3 no event yet");
        pin_in[0] = 1; step(4);
        do_poll(0, 1, "R3 rising sets flag");
        do_poll(0, 0, "R6 poll cleared flag");
        pin_in[0] = 0; step(4);
        do_poll(0, 0, "R3 falling ignored");
        // R4 both edges
        wr(1, 4'b0110);
        do_poll(1, 0, "R4 no spurious set in both mode");
        pin_in[1] = 1; step(4);
        do_poll(1, 1, "R4 rising edge");
        pin_in[1] = 0; step(4);
        do_poll(1, 1, "R4 falling edge");
        // R5 polarity write sets flag (pin low, new polarity low)
        wr(0, 4'b0000); step(1);
        do_poll(0, 1, "R5 polarity write sets flag");
        // R7 enabled: interrupt instead of poll
        pin_in[0] = 1; step(4);
        wr(2, 4'b0001);
        @(posedge clk); #1; poll[0] = 1; pin_in[0] = 0;
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1;
            if (irq[0]) seen++;
            check("R7 poll no effect while enabled", {3'b0, skip[0]}, 4'h0);
        end
        poll[0] = 0;
        check("R7 single irq cycle", 4'(seen), 4'd1);
        wr(2, 4'b0000);
        do_poll(0, 0, "R7 flag consumed by irq");
        // R8 set wins over poll clear
        wr(0, 4'b0010);
        pin_in[0] = 1; step(4);
        @(posedge clk); #1; pin_in[0] = 0;
        @(posedge clk); #1;
        @(posedge clk); #1; poll[0] = 1;
        @(posedge clk); #1; poll[0] = 0;
        check("R8 poll sees old flag", {3'b0, skip[0]}, 4'h1);
        do_poll(0, 1, "R8 flag survived clear");
        // R9 timer gate
        wr(1, 4'b0011);
        @(posedge clk); #1; pin_in[1] = 1;
        @(posedge clk); #1;
        check("R9 gate not yet", {3'b0, tmr_gate[1]}, 4'h0);
        @(posedge clk); #1;
        check("R9 gate follows pin", {3'b0, tmr_gate[1]}, 4'h1);
        wr(1, 4'b0010); step(1);
        check("R9 gate off when disabled", {3'b0, tmr_gate[1]}, 4'h0);
        // R10 retaining reset
        wr(0, 4'b1010); wr(2, 4'b0011);
        @(posedge clk); #1; keep_rst = 1;
        @(posedge clk); #1; keep_rst = 0;
        rd(2, 4'h0, "R10 enable cleared");
        rd(0, 4'b1010, "R10 ctrl0 kept");
        rd(1, 4'b0010, "R10 ctrl1 kept");
        step(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule